// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts a 32-bit number of seconds down to zero and raises an alarm when it gets there. Software writes the number of seconds until the alarm into a load register and sets a run bit. From then on, each pulse on the one-second tick input takes one from the count. When the count steps from one to zero, a sticky pending flag is set and the counter stops at zero.

The pending flag is cleared by writing a one to it. Two outputs follow the flag, each through its own gate bit. The interrupt line is high while the flag is set and the interrupt gate is open. The wakeup request is high while the flag is set and the wakeup bit is set. All registers sit on a simple single-cycle write bus with a combinational read port.

Top module: `secs_countdown_alarm`

## Requirements
- R1: After reset the remaining count, loaded value, run bit, interrupt gate, wakeup bit and pending flag are all zero. `alarm_irq` and `wake_req` are low.
- R2: A write to offset 0x20 stores the 32-bit data. That value reads back at 0x20 and becomes the remaining count, readable at 0x24. A load write wins over a tick in the same cycle.
- R3: With bit 0 of offset 0x28 set and a non-zero count, each clock cycle with `sec_tick` high lowers the count by exactly one. With that bit clear, or with no tick, the count holds.
- R4: A tick that takes the count from 1 to 0 sets the pending flag (bit 0 of offset 0x30) in the same edge. The count then stays at 0 under further ticks.
- R5: Writing a data word with bit 0 set to offset 0x30 clears the pending flag. Writing a word with bit 0 clear leaves the flag unchanged.
- R6: When a clearing write to 0x30 and an expiry fall in the same cycle, the pending flag ends up set.
- R7: `alarm_irq` is high exactly when the pending flag is set and bit 0 of offset 0x2C is set.
- R8: `wake_req` is high exactly when the pending flag is set and bit 0 of offset 0x50 is set.
- R9: Writing 0 to offset 0x20 clears the count. A zero count never sets the pending flag, however many ticks arrive.
- R10: Registers 0x28, 0x2C, 0x30 and 0x50 read back only their bit 0, with all other bits zero. Any address not listed here reads 0, and writes to such an address change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wakeup request |

## Verification
A register write or a tick takes effect at the clock edge where it is sampled. Because reads are combinational, the new count, pending flag, `alarm_irq` and `wake_req` can all be observed one edge after the stimulus cycle. The bench drives every input on a falling edge and holds it for one full cycle. It checks readback and outputs on the next falling edge, half a period after the edge that updated them. Same-cycle collisions (tick with load, expiry with clear) are built by driving both inputs within one such cycle.

// File: rtl/secs_countdown_alarm.sv
module secs_countdown_alarm #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_irq,
  output logic              wake_req
);

  localparam logic [ADDR_W-1:0] OFS_LOAD = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_CUR  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] OFS_RUN  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] OFS_IEN  = ADDR_W'('h2C);
  localparam logic [ADDR_W-1:0] OFS_STA  = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] OFS_WAKE = ADDR_W'('h50);
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  logic [DATA_W-1:0] load_q, cnt_q;
  logic run_q, ien_q, wake_q, pend_q;

  wire sel_load = bus_we && (bus_addr == OFS_LOAD);
  wire sel_run  = bus_we && (bus_addr == OFS_RUN);
  wire sel_ien  = bus_we && (bus_addr == OFS_IEN);
  wire sel_sta  = bus_we && (bus_addr == OFS_STA);
  wire sel_wake = bus_we && (bus_addr == OFS_WAKE);

  wire step   = run_q && sec_tick && !sel_load && (cnt_q != '0);
  wire expire = step && (cnt_q == ONE);
  wire clr    = sel_sta && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
    end else if (sel_load) begin
      load_q <= bus_wdata;
      cnt_q  <= bus_wdata;
    end else if (step) begin
      cnt_q  <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (sel_run)  run_q  <= bus_wdata[0];
      if (sel_ien)  ien_q  <= bus_wdata[0];
      if (sel_wake) wake_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= expire || (pend_q && !clr);
  end

  assign alarm_irq = pend_q && ien_q;
  assign wake_req  = pend_q && wake_q;

  always_comb begin
    case (bus_addr)
      OFS_LOAD: bus_rdata = load_q;
      OFS_CUR:  bus_rdata = cnt_q;
      OFS_RUN:  bus_rdata = DATA_W'(run_q);
      OFS_IEN:  bus_rdata = DATA_W'(ien_q);
      OFS_STA:  bus_rdata = DATA_W'(pend_q);
      OFS_WAKE: bus_rdata = DATA_W'(wake_q);
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/secs_countdown_alarm_chk.sv
module secs_countdown_alarm_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] cnt_q,
  input logic              run_q,
  input logic              ien_q,
  input logic              wake_q,
  input logic              pend_q,
  input logic              alarm_irq,
  input logic              wake_req
);

  logic ld_w, sta_w;
  assign ld_w  = bus_we && (bus_addr == ADDR_W'('h20));
  assign sta_w = bus_we && (bus_addr == ADDR_W'('h30));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && sec_tick && !ld_w && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - DATA_W'(1));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_w && (!run_q || !sec_tick) |=> $stable(cnt_q));

  // R4
  expiry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && sec_tick && !ld_w && (cnt_q == DATA_W'(1)) |=> pend_q && (cnt_q == '0));

  // R9
  zero_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) && !ld_w |=> (cnt_q == '0) && (pend_q == $past(pend_q) || !pend_q));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sta_w && bus_wdata[0] && !(run_q && sec_tick && cnt_q == DATA_W'(1)) |=> !pend_q);

  // R6
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sta_w && bus_wdata[0] && run_q && sec_tick && !ld_w && (cnt_q == DATA_W'(1)) |=> pend_q);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> pend_q && ien_q);

  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> pend_q && wake_q);

endmodule

bind secs_countdown_alarm secs_countdown_alarm_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q), .run_q(run_q),
  .ien_q(ien_q), .wake_q(wake_q), .pend_q(pend_q), .alarm_irq(alarm_irq),
  .wake_req(wake_req)
);

// File: tb/secs_countdown_alarm_bench.sv
module secs_countdown_alarm_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic alarm_irq, wake_req;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  secs_countdown_alarm u_secs_countdown_alarm (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq), .wake_req(wake_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [7:0] a, logic [31:0] d, logic t);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; sec_tick = t;
    @(negedge clk);
    bus_we = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 32'h0, 1'b1);
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic t_reset();
    rd("R1 count", 8'h24, 32'h0);
    rd("R1 load", 8'h20, 32'h0);
    rd("R1 run", 8'h28, 32'h0);
    rd("R1 pending", 8'h30, 32'h0);
    check("R1 irq", alarm_irq, 1'b0);
    check("R1 wake", wake_req, 1'b0);
  endtask

  task automatic t_load();
    wr(8'h20, 32'hDEADBEEF);
    rd("R2 load readback", 8'h20, 32'hDEADBEEF);
    rd("R2 count", 8'h24, 32'hDEADBEEF);
    wr(8'h20, 32'h0);
    rd("R9 zero load", 8'h24, 32'h0);
  endtask

  task automatic t_count();
    wr(8'h20, 32'd7);
    ticks(3);
    rd("R3 disabled hold", 8'h24, 32'd7);
    wr(8'h28, 32'h1);
    ticks(3);
    rd("R3 three ticks", 8'h24, 32'd4);
    repeat (4) @(negedge clk);
    rd("R3 no tick hold", 8'h24, 32'd4);
    cyc(1'b1, 8'h20, 32'd9, 1'b1);
    rd("R2 load beats tick", 8'h24, 32'd9);
  endtask

  task automatic t_expire();
    wr(8'h2C, 32'h1);
    wr(8'h20, 32'd2);
    ticks(1);
    rd("R4 before expiry pending", 8'h30, 32'h0);
    rd("R4 count 1", 8'h24, 32'd1);
    check("R7 irq before", alarm_irq, 1'b0);
    ticks(1);
    rd("R4 pending set", 8'h30, 32'h1);
    rd("R4 count 0", 8'h24, 32'd0);
    check("R7 irq raised", alarm_irq, 1'b1);
    check("R8 wake masked", wake_req, 1'b0);
    ticks(3);
    rd("R4 stays zero", 8'h24, 32'd0);
  endtask

  task automatic t_clear();
    wr(8'h30, 32'hFFFF_FFFE);
    rd("R5 write0 keeps", 8'h30, 32'h1);
    wr(8'h50, 32'h1);
    check("R8 wake raised", wake_req, 1'b1);
    wr(8'h2C, 32'h0);
    check("R7 irq gated off", alarm_irq, 1'b0);
    wr(8'h30, 32'h1);
    rd("R5 cleared", 8'h30, 32'h0);
    check("R8 wake dropped", wake_req, 1'b0);
    wr(8'h2C, 32'h1);
    check("R7 irq stays low", alarm_irq, 1'b0);
  endtask

  task automatic t_zero();
    wr(8'h20, 32'h0);
    ticks(4);
    rd("R9 no pending", 8'h30, 32'h0);
    check("R9 irq low", alarm_irq, 1'b0);
  endtask

  task automatic t_collide();
    wr(8'h20, 32'd1);
    cyc(1'b1, 8'h30, 32'h1, 1'b1);
    rd("R6 pending wins", 8'h30, 32'h1);
    rd("R6 count", 8'h24, 32'd0);
    wr(8'h30, 32'h1);
  endtask

  task automatic t_map();
    wr(8'h40, 32'hFFFF_FFFF);
    rd("R10 unmapped read", 8'h40, 32'h0);
    rd("R10 unmapped no effect load", 8'h20, 32'd1);
    wr(8'h28, 32'hFFFF_FFFF);
    rd("R10 run bit only", 8'h28, 32'h1);
    wr(8'h28, 32'hFFFF_FFFE);
    rd("R10 run cleared by bit0", 8'h28, 32'h0);
    rd("R10 wake bit only", 8'h50, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_count();
    t_expire();
    t_clear();
    t_zero();
    t_collide();
    t_map();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule